// File: doc/BRIEF.md
# Two-Phase Register Processor Core

This block is a small 32-bit processor core that runs every instruction in exactly two clock cycles. In the first cycle it puts its program counter on a word-addressed instruction memory port, captures the returned word in an instruction register and steps the program counter by one. In the second cycle it decodes the captured word and reads two operands from a sixteen-entry register file in parallel. It combines them in a combinational ALU and writes the result back on the edge that closes the cycle.

A small state machine sequences the two phases. It has a state register and separate next-state logic. A halt instruction parks the machine in a stop state, and only reset releases it. The instruction memory is outside the core and answers combinationally. A debug port shows the program counter, and it can also show any one register selected by an index. This lets the results of a program be observed without any data-memory path.

Top module: `cpu2_core`

## Requirements
- R1: While `rst_n` is low, the program counter, the instruction register and all sixteen registers are cleared and the controller is put in the fetch phase. After release, `dbg_pc` reads 0 and every register reads 0.
- R2: During fetch, `imem_addr` equals the program counter. The program counter advances by exactly 1 on the edge that ends fetch and holds on the edge that ends execute. A new instruction therefore starts every second clock edge.
- R3: Instructions are encoded as follows:
  - opcode in bits [31:28]
  - destination register in [27:24]
  - source A in [23:20]
  - source B in [19:16]
  - a 16-bit immediate in [15:0]

  Opcode 0 writes A+B and opcode 1 writes A-B, both modulo 2^32.
- R4: Opcode 2 writes A AND B, opcode 3 writes A OR B and opcode 4 writes A XOR B.
- R5: Opcode 5 writes A plus the immediate, sign-extended from bit 15 to 32 bits.
- R6: The result register is written on the edge that ends the execute cycle, and not before. The instruction fetched right after it reads the new value.
- R7: Register 0 always reads as zero, both as an operand and on the debug port. A write that targets it has no effect.
- R8: Both source operands are read in the same cycle, including when the two sources name the same register.
- R9: Opcode 15 (halt) stops the core after its execute cycle. The program counter stays at the halt instruction's address plus one, `imem_addr` stays constant, and no further instruction changes any register.
- R10: Opcodes 6 to 14 change no register. They still take two cycles and advance the program counter by one.
- R11: `dbg_reg` shows the current contents of the register selected by `dbg_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with `clk` |
| imem_addr | output | AW (8) | Word address of the instruction being fetched |
| imem_rdata | input | 32 | Instruction word returned for `imem_addr` in the same cycle |
| dbg_sel | input | 4 | Register index shown on `dbg_reg` |
| dbg_pc | output | AW (8) | Current program counter |
| dbg_reg | output | 32 | Contents of the register selected by `dbg_sel` |

## Verification
The phase timing is tried with a dependent chain of immediate adds. The program counter and the destination register are sampled after every edge, which separates a write on the fetch edge from a write on the execute edge. It also catches a counter that moves on both edges. The ALU program uses an all-ones operand, so that carry wrap, borrow and sign extension each give a value no other operation would produce. Reusing one register for both sources, targeting register 0, and running the unused opcodes each show whether some path leaks a write. A halt followed by live instructions shows whether the stop state really freezes the counter and the register file.

// File: rtl/cpu2_pkg.sv
package cpu2_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 16;
  localparam int RSEL = $clog2(NREG);

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_ADDI = 4'd5,
    OP_HALT = 4'd15
  } opcode_t;

  typedef enum logic [1:0] {
    PH_FETCH = 2'd0,
    PH_EXEC  = 2'd1,
    PH_STOP  = 2'd2
  } phase_t;

  typedef struct packed {
    logic [3:0]      op;
    logic [RSEL-1:0] rd;
    logic [RSEL-1:0] ra;
    logic [RSEL-1:0] rb;
    logic [15:0]     imm;
  } instr_t;
endpackage

// File: rtl/cpu2_ctrl.sv
module cpu2_ctrl
  import cpu2_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   halt_op,
  output phase_t phase,
  output logic   fetch_en,
  output logic   exec_en
);
  phase_t phase_nxt;

  always_comb begin
    phase_nxt = phase;
    unique case (phase)
      PH_FETCH: phase_nxt = PH_EXEC;
      PH_EXEC:  phase_nxt = halt_op ? PH_STOP : PH_FETCH;
      PH_STOP:  phase_nxt = PH_STOP;
      default:  phase_nxt = PH_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_FETCH;
    else        phase <= phase_nxt;
  end

  assign fetch_en = (phase == PH_FETCH);
  assign exec_en  = (phase == PH_EXEC);
endmodule

// File: rtl/cpu2_regfile.sv
module cpu2_regfile
  import cpu2_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [RSEL-1:0] waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RSEL-1:0] raddr_a,
  input  logic [RSEL-1:0] raddr_b,
  input  logic [RSEL-1:0] raddr_d,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b,
  output logic [XLEN-1:0] rdata_d
);
  logic [XLEN-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    logic hit;
    assign hit = we && (waddr == RSEL'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   regs[i] <= '0;
      else if (hit) regs[i] <= wdata;
    end
  end

  assign rdata_a = regs[raddr_a];
  assign rdata_b = regs[raddr_b];
  assign rdata_d = regs[raddr_d];
endmodule

// File: rtl/cpu2_alu.sv
module cpu2_alu
  import cpu2_pkg::*;
(
  input  logic [3:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [15:0]     imm,
  output logic [XLEN-1:0] result,
  output logic            writes
);
  logic [XLEN-1:0] imm_ext;
  assign imm_ext = {{(XLEN-16){imm[15]}}, imm};

  always_comb begin
    result = '0;
    writes = 1'b1;
    unique case (op)
      OP_ADD:  result = a + b;
      OP_SUB:  result = a - b;
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_XOR:  result = a ^ b;
      OP_ADDI: result = a + imm_ext;
      default: writes = 1'b0;
    endcase
  end
endmodule

// File: rtl/cpu2_core.sv
module cpu2_core
  import cpu2_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [AW-1:0]   imem_addr,
  input  logic [XLEN-1:0] imem_rdata,
  input  logic [RSEL-1:0] dbg_sel,
  output logic [AW-1:0]   dbg_pc,
  output logic [XLEN-1:0] dbg_reg
);
  phase_t          phase;
  logic            fetch_en, exec_en;
  logic [AW-1:0]   pc;
  instr_t          ir;
  logic [XLEN-1:0] opa, opb, alu_y;
  logic            alu_wr, rf_we, halt_op;

  assign halt_op = (ir.op == OP_HALT);

  cpu2_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_op  (halt_op),
    .phase    (phase),
    .fetch_en (fetch_en),
    .exec_en  (exec_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pc <= '0;
    else if (fetch_en) pc <= pc + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ir <= '0;
    else if (fetch_en) ir <= instr_t'(imem_rdata);
  end

  assign rf_we = exec_en && alu_wr;

  cpu2_regfile u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (rf_we),
    .waddr   (ir.rd),
    .wdata   (alu_y),
    .raddr_a (ir.ra),
    .raddr_b (ir.rb),
    .raddr_d (dbg_sel),
    .rdata_a (opa),
    .rdata_b (opb),
    .rdata_d (dbg_reg)
  );

  cpu2_alu u_alu (
    .op     (ir.op),
    .a      (opa),
    .b      (opb),
    .imm    (ir.imm),
    .result (alu_y),
    .writes (alu_wr)
  );

  assign imem_addr = pc;
  assign dbg_pc    = pc;
endmodule

// File: rtl/cpu2_core_chk.sv
module cpu2_core_chk
  import cpu2_pkg::*;
#(
  parameter int AW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input phase_t          phase,
  input logic            rf_we,
  input logic [AW-1:0]   dbg_pc,
  input logic [AW-1:0]   imem_addr,
  input logic [RSEL-1:0] dbg_sel,
  input logic [XLEN-1:0] dbg_reg
);
  // R1
  reset_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> dbg_pc == '0);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dbg_pc) |-> dbg_pc == $past(dbg_pc) + AW'(1));

  // R2
  fetch_then_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_FETCH |=> phase == PH_EXEC);

  // R6
  write_in_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> phase == PH_EXEC);

  // R7
  zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_sel == '0 |-> dbg_reg == '0);

  // R9
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_STOP |=> phase == PH_STOP && $stable(dbg_pc) && $stable(imem_addr) && !rf_we);
endmodule

bind cpu2_core cpu2_core_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase     (phase),
  .rf_we     (rf_we),
  .dbg_pc    (dbg_pc),
  .imem_addr (imem_addr),
  .dbg_sel   (dbg_sel),
  .dbg_reg   (dbg_reg)
);

// File: tb/cpu2_core_tb.sv
`timescale 1ns/1ps
module cpu2_core_tb;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [AW-1:0] imem_addr;
  logic [31:0] imem_rdata;
  logic [3:0]  dbg_sel;
  logic [AW-1:0] dbg_pc;
  logic [31:0] dbg_reg;
  logic [31:0] imem [1<<AW];

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  assign imem_rdata = imem[imem_addr];

  cpu2_core #(.AW(AW)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dbg_sel    (dbg_sel),
    .dbg_pc     (dbg_pc),
    .dbg_reg    (dbg_reg)
  );

  function automatic logic [31:0] enc(input logic [3:0] op, input logic [3:0] rd,
                                      input logic [3:0] ra, input logic [3:0] rb,
                                      input logic [15:0] imm);
    return {op, rd, ra, rb, imm};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic rd_reg(input int idx, output logic [31:0] v);
    dbg_sel = idx[3:0];
    #0.5;
    v = dbg_reg;
  endtask

  task automatic chk_reg(input string tag, input int idx, input logic [31:0] exp);
    logic [31:0] v;
    rd_reg(idx, v);
    check(tag, v, exp);
  endtask

  task automatic clear_mem();
    for (int i = 0; i < (1 << AW); i++) imem[i] = 32'hF000_0000;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1: state after reset
  task automatic t_reset();
    clear_mem();
    imem[0] = enc(4'd5, 4'd1, 4'd0, 4'd0, 16'd9);
    do_reset();
    run(12);
    do_reset();
    check("R1 pc", 32'(dbg_pc), 0);
    check("R1 imem_addr", 32'(imem_addr), 0);
    for (int r = 0; r < 16; r++) chk_reg("R1 reg", r, 0);
  endtask

  // R2 R6: two-edge timing and back-to-back dependency
  task automatic t_timing();
    clear_mem();
    imem[0] = enc(4'd5, 4'd1, 4'd0, 4'd0, 16'd5);
    imem[1] = enc(4'd5, 4'd2, 4'd1, 4'd0, 16'd3);
    do_reset();
    @(negedge clk);
    check("R2 pc after fetch", 32'(dbg_pc), 1);
    check("R2 imem_addr follows pc", 32'(imem_addr), 1);
    chk_reg("R6 no write on fetch edge", 1, 0);
    @(negedge clk);
    check("R2 pc holds in exec", 32'(dbg_pc), 1);
    chk_reg("R6 write on exec edge", 1, 5);
    @(negedge clk);
    check("R2 pc second fetch", 32'(dbg_pc), 2);
    chk_reg("R6 r2 not yet", 2, 0);
    @(negedge clk);
    chk_reg("R6 dependent read", 2, 8);
  endtask

  // R3 R4 R5 R8 R11: ALU patterns
  task automatic t_alu();
    clear_mem();
    imem[0]  = enc(4'd5, 4'd1, 4'd0, 4'd0, 16'hFFFF);
    imem[1]  = enc(4'd5, 4'd2, 4'd0, 4'd0, 16'h0030);
    imem[2]  = enc(4'd0, 4'd3, 4'd1, 4'd2, 16'h0);
    imem[3]  = enc(4'd1, 4'd4, 4'd2, 4'd1, 16'h0);
    imem[4]  = enc(4'd1, 4'd5, 4'd0, 4'd2, 16'h0);
    imem[5]  = enc(4'd2, 4'd6, 4'd1, 4'd2, 16'h0);
    imem[6]  = enc(4'd5, 4'd7, 4'd0, 4'd0, 16'h0F0F);
    imem[7]  = enc(4'd3, 4'd8, 4'd7, 4'd2, 16'h0);
    imem[8]  = enc(4'd4, 4'd9, 4'd7, 4'd1, 16'h0);
    imem[9]  = enc(4'd5, 4'd10, 4'd0, 4'd0, 16'h7FFF);
    imem[10] = enc(4'd0, 4'd11, 4'd7, 4'd7, 16'h0);
    imem[11] = enc(4'd5, 4'd12, 4'd1, 4'd0, 16'h8000);
    do_reset();
    run(30);
    chk_reg("R5 negative imm", 1, 32'hFFFF_FFFF);
    chk_reg("R3 add wraps", 3, 32'h0000_002F);
    chk_reg("R3 sub borrow", 4, 32'h0000_0031);
    chk_reg("R3 sub from zero", 5, 32'hFFFF_FFD0);
    chk_reg("R4 and", 6, 32'h0000_0030);
    chk_reg("R4 or", 8, 32'h0000_0F3F);
    chk_reg("R4 xor", 9, 32'hFFFF_F0F0);
    chk_reg("R5 positive imm", 10, 32'h0000_7FFF);
    chk_reg("R8 same source twice", 11, 32'h0000_1E1E);
    chk_reg("R5 min imm", 12, 32'hFFFF_7FFF);
    chk_reg("R11 untouched reg", 13, 0);
  endtask

  // R7: register zero
  task automatic t_zero();
    clear_mem();
    imem[0] = enc(4'd5, 4'd0, 4'd0, 4'd0, 16'd9);
    imem[1] = enc(4'd0, 4'd1, 4'd0, 4'd0, 16'd0);
    imem[2] = enc(4'd5, 4'd2, 4'd0, 4'd0, 16'd4);
    do_reset();
    run(10);
    chk_reg("R7 r0 debug", 0, 0);
    chk_reg("R7 r0 operand", 1, 0);
    chk_reg("R7 r0 as source", 2, 4);
  endtask

  // R10: unused opcodes
  task automatic t_nop();
    clear_mem();
    imem[0] = enc(4'd5, 4'd1, 4'd0, 4'd0, 16'd1);
    for (int k = 6; k <= 14; k++) imem[k-5] = enc(4'(k), 4'd1, 4'd1, 4'd1, 16'h1234);
    imem[10] = enc(4'd5, 4'd2, 4'd1, 4'd0, 16'd1);
    do_reset();
    run(4);
    check("R10 pc advances", 32'(dbg_pc), 2);
    run(30);
    chk_reg("R10 r1 kept", 1, 1);
    chk_reg("R10 later instr", 2, 2);
    check("R10 pc at halt", 32'(dbg_pc), 12);
  endtask

  // R9: halt
  task automatic t_halt();
    clear_mem();
    imem[0] = enc(4'd5, 4'd1, 4'd0, 4'd0, 16'd7);
    imem[1] = enc(4'd15, 4'd0, 4'd0, 4'd0, 16'd0);
    imem[2] = enc(4'd5, 4'd3, 4'd0, 4'd0, 16'd11);
    imem[3] = enc(4'd5, 4'd1, 4'd0, 4'd0, 16'd2);
    do_reset();
    run(4);
    check("R9 pc at halt", 32'(dbg_pc), 2);
    run(20);
    check("R9 pc frozen", 32'(dbg_pc), 2);
    check("R9 imem_addr frozen", 32'(imem_addr), 2);
    chk_reg("R9 r1 kept", 1, 7);
    chk_reg("R9 after halt skipped", 3, 0);
  endtask

  initial begin
    rst_n = 1'b0;
    dbg_sel = '0;
    t_reset();
    t_timing();
    t_alu();
    t_zero();
    t_nop();
    t_halt();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule